// File: doc/BRIEF.md
# Data Address Generation Unit

This unit forms the effective data-space address for every load and store of an 8-bit core and produces the new pointer value when an access moves its pointer. It keeps a mirror of the three 16-bit pointers, P0, P1 and P2, that live in the six highest general registers. Each time the core writes one of those registers through the register-file write port, the unit updates its matching pointer byte. A request carries an addressing mode, a pointer select, a 16-bit absolute address, a 6-bit offset and a 6-bit short I/O port number. One shared 16-bit adder serves all modes.

The data space is a single flat map. The 32 general registers come first, the 64 I/O registers follow them, and 1024 bytes of SRAM come after that. Any higher address is flagged. The result is registered: the effective address, a region code, a bit-access flag and an error flag appear one cycle after the request. A pointer that the access changes is returned on a one-cycle write-back strobe, split into a low byte and a high byte for the register pair. The internal mirror takes the new value at the same edge.

Top module: `data_agu`

## Requirements
- R1: After reset every output is 0 and all three pointers read as 0x0000.
- R2: A write on the register port to index 26/27 sets the low/high byte of P0, 28/29 of P1, and 30/31 of P2. A write to any lower index leaves all pointers unchanged.
- R3: Absolute mode (mode 0) gives `out_ea` equal to `req_dir` for any 16-bit value. There is no write-back.
- R4: Plain pointer mode (mode 1) gives `out_ea` equal to the selected pointer (select 0 = P0, 1 = P1, 2 = P2). There is no write-back.
- R5: Offset mode (mode 2) with P1 or P2 gives the pointer plus the zero-extended 0..63 offset, modulo 2^16. With P0 it raises `out_err` and does not write back.
- R6: Pre-decrement mode (mode 3) gives pointer minus 1 as the address and writes that same value back. 0x0000 wraps to 0xFFFF.
- R7: Post-increment mode (mode 4) gives the old pointer as the address and writes back pointer plus 1. 0xFFFF wraps to 0x0000.
- R8: Short I/O mode (mode 5) gives `req_io` + 0x20. `out_bit_ok` is 1 exactly when `out_ea` lies in 0x20..0x3F (I/O ports 0x00..0x1F).
- R9: `out_region` is 0 for addresses 0..31, 1 for 32..95, 2 for 96..1119 and 3 for 1120 and above.
- R10: The outputs follow a request by one clock. `out_vld` and `wb_vld` are single-cycle pulses. `wb_sel` names the pair, and `wb_lo`/`wb_hi` carry the new value.
- R11: When a write-back and a register-port write hit the same pointer in one cycle, the write-back wins. A register-port write to a different pointer in that cycle still takes effect.
- R12: Mode codes 6 and 7, or pointer select 3 in a pointer mode, raise `out_err` with `out_ea` = 0, region 0 and no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Address request this cycle |
| req_mode | input | 3 | Addressing mode code |
| req_sel | input | 2 | Pointer select |
| req_dir | input | 16 | Absolute address |
| req_disp | input | 6 | Unsigned offset |
| req_io | input | 6 | Short I/O port number |
| gpr_we | input | 1 | Register-file write strobe |
| gpr_idx | input | 5 | Register-file write index |
| gpr_data | input | 8 | Register-file write byte |
| out_vld | output | 1 | Result valid |
| out_ea | output | 16 | Effective address |
| out_region | output | 2 | Region code |
| out_bit_ok | output | 1 | Address is single-bit accessible |
| out_err | output | 1 | Illegal mode or select |
| wb_vld | output | 1 | Pointer write-back strobe |
| wb_sel | output | 2 | Pointer being written back |
| wb_lo | output | 8 | New pointer low byte |
| wb_hi | output | 8 | New pointer high byte |

## Verification
The properties assume that the mode and select inputs are driven only while `req_vld` is high. They also assume that the low and high bytes of a pointer arrive as separate register-port writes. The pointer-arithmetic properties read the request mode one cycle back, so they rely on the inputs being held steady around the sampling edge. The directed stimulus changes every input on the falling edge and returns `req_vld` and `gpr_we` to 0 after each cycle. Each pointer is loaded byte by byte before it is used, and the illegal mode codes and select values are sent only in the dedicated error scenario.

// File: rtl/agu_pkg.sv
package agu_pkg;
    typedef enum logic [2:0] {
        AM_DIRECT  = 3'd0,
        AM_IND     = 3'd1,
        AM_DISP    = 3'd2,
        AM_PREDEC  = 3'd3,
        AM_POSTINC = 3'd4,
        AM_IOSHORT = 3'd5
    } amode_e;

    typedef enum logic [1:0] {
        RG_GPR  = 2'd0,
        RG_IO   = 2'd1,
        RG_SRAM = 2'd2,
        RG_NONE = 2'd3
    } region_e;

    localparam logic [1:0] PSEL_P0 = 2'd0;
endpackage

// File: rtl/agu_ptr_file.sv
module agu_ptr_file #(
    parameter int ADDR_W = 16,
    parameter int GPR_N  = 32,
    parameter int PTR_N  = 3,
    parameter int SEL_W  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       gpr_we,
    input  logic [$clog2(GPR_N)-1:0]   gpr_idx,
    input  logic [ADDR_W/2-1:0]        gpr_data,
    input  logic                       wb_en,
    input  logic [SEL_W-1:0]           wb_sel,
    input  logic [ADDR_W-1:0]          wb_val,
    input  logic [SEL_W-1:0]           rd_sel,
    output logic [ADDR_W-1:0]          rd_ptr,
    output logic                       rd_ok
);
    localparam int HALF  = ADDR_W / 2;
    localparam int IDX_W = $clog2(GPR_N);
    localparam int PBASE = GPR_N - 2 * PTR_N;

    logic [ADDR_W-1:0] ptr_all [PTR_N];

    for (genvar g = 0; g < PTR_N; g++) begin : g_pair
        localparam logic [IDX_W-1:0] LO_IDX = IDX_W'(PBASE + 2 * g);
        localparam logic [IDX_W-1:0] HI_IDX = IDX_W'(PBASE + 2 * g + 1);
        logic [ADDR_W-1:0] p_d, p_q;

        always_comb begin
            p_d = p_q;
            if (wb_en && wb_sel == SEL_W'(g)) begin
                p_d = wb_val;                       // write-back wins
            end else if (gpr_we && gpr_idx == LO_IDX) begin
                p_d[HALF-1:0] = gpr_data;
            end else if (gpr_we && gpr_idx == HI_IDX) begin
                p_d[ADDR_W-1:HALF] = gpr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) p_q <= '0;
            else        p_q <= p_d;
        end

        assign ptr_all[g] = p_q;
    end

    always_comb begin
        rd_ptr = '0;
        for (int i = 0; i < PTR_N; i++) begin
            if (rd_sel == SEL_W'(i)) rd_ptr = ptr_all[i];
        end
    end

    assign rd_ok = rd_sel < SEL_W'(PTR_N);
endmodule

// File: rtl/agu_adder.sv
module agu_adder
    import agu_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DISP_W  = 6,
    parameter int IO_W    = 6,
    parameter int IO_BASE = 32
) (
    input  amode_e              mode,
    input  logic [ADDR_W-1:0]   ptr,
    input  logic [ADDR_W-1:0]   dir,
    input  logic [DISP_W-1:0]   disp,
    input  logic [IO_W-1:0]     io,
    output logic [ADDR_W-1:0]   ea,
    output logic [ADDR_W-1:0]   wb_val
);
    logic [ADDR_W-1:0] op_a, op_b, sum;

    always_comb begin
        op_a = '0;
        op_b = '0;
        case (mode)
            AM_DIRECT:  op_b = dir;
            AM_IND:     op_a = ptr;
            AM_DISP:    begin op_a = ptr; op_b = {{(ADDR_W-DISP_W){1'b0}}, disp}; end
            AM_PREDEC:  begin op_a = ptr; op_b = '1; end
            AM_POSTINC: begin op_a = ptr; op_b = ADDR_W'(1); end
            AM_IOSHORT: begin op_a = ADDR_W'(IO_BASE); op_b = {{(ADDR_W-IO_W){1'b0}}, io}; end
            default:    ;
        endcase
    end

    assign sum    = op_a + op_b;
    assign ea     = (mode == AM_POSTINC) ? ptr : sum;
    assign wb_val = sum;
endmodule

// File: rtl/agu_region.sv
module agu_region
    import agu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int GPR_N  = 32,
    parameter int IO_N   = 64,
    parameter int SRAM_N = 1024
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic              bit_ok
);
    localparam logic [ADDR_W-1:0] L_IO   = ADDR_W'(GPR_N);
    localparam logic [ADDR_W-1:0] L_SRAM = ADDR_W'(GPR_N + IO_N);
    localparam logic [ADDR_W-1:0] L_TOP  = ADDR_W'(GPR_N + IO_N + SRAM_N);
    localparam logic [ADDR_W-1:0] L_BIT  = ADDR_W'(GPR_N + IO_N / 2);

    always_comb begin
        if (addr < L_IO)        region = RG_GPR;
        else if (addr < L_SRAM) region = RG_IO;
        else if (addr < L_TOP)  region = RG_SRAM;
        else                    region = RG_NONE;
    end

    assign bit_ok = (addr >= L_IO) && (addr < L_BIT);
endmodule

// File: rtl/data_agu.sv
module data_agu
    import agu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int GPR_N  = 32,
    parameter int IO_N   = 64,
    parameter int SRAM_N = 1024,
    parameter int PTR_N  = 3,
    parameter int DISP_W = 6,
    parameter int IO_W   = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_vld,
    input  logic [2:0]                req_mode,
    input  logic [1:0]                req_sel,
    input  logic [ADDR_W-1:0]         req_dir,
    input  logic [DISP_W-1:0]         req_disp,
    input  logic [IO_W-1:0]           req_io,
    input  logic                      gpr_we,
    input  logic [$clog2(GPR_N)-1:0]  gpr_idx,
    input  logic [ADDR_W/2-1:0]       gpr_data,
    output logic                      out_vld,
    output logic [ADDR_W-1:0]         out_ea,
    output logic [1:0]                out_region,
    output logic                      out_bit_ok,
    output logic                      out_err,
    output logic                      wb_vld,
    output logic [1:0]                wb_sel,
    output logic [ADDR_W/2-1:0]       wb_lo,
    output logic [ADDR_W/2-1:0]       wb_hi
);
    localparam int HALF = ADDR_W / 2;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] ea;
        logic [1:0]        region;
        logic              bit_ok;
        logic              err;
        logic              wb;
        logic [1:0]        wb_sel;
        logic [ADDR_W-1:0] wb_val;
    } out_t;

    out_t              st_d, st_q;
    amode_e            mode;
    logic [ADDR_W-1:0] ptr_rd, ea_c, wb_c, ea_m;
    logic              sel_ok, uses_ptr, legal, err_c, do_wb;
    region_e           region_c;
    logic              bit_ok_c;

    assign mode = amode_e'(req_mode);

    agu_ptr_file #(.ADDR_W(ADDR_W), .GPR_N(GPR_N), .PTR_N(PTR_N), .SEL_W(2)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .gpr_we(gpr_we), .gpr_idx(gpr_idx), .gpr_data(gpr_data),
        .wb_en(do_wb), .wb_sel(req_sel), .wb_val(wb_c),
        .rd_sel(req_sel), .rd_ptr(ptr_rd), .rd_ok(sel_ok)
    );

    agu_adder #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .IO_W(IO_W), .IO_BASE(GPR_N)) u_add (
        .mode(mode), .ptr(ptr_rd), .dir(req_dir), .disp(req_disp), .io(req_io),
        .ea(ea_c), .wb_val(wb_c)
    );

    agu_region #(.ADDR_W(ADDR_W), .GPR_N(GPR_N), .IO_N(IO_N), .SRAM_N(SRAM_N)) u_reg (
        .addr(ea_m), .region(region_c), .bit_ok(bit_ok_c)
    );

    always_comb begin
        uses_ptr = (mode == AM_IND) || (mode == AM_DISP) ||
                   (mode == AM_PREDEC) || (mode == AM_POSTINC);
        legal    = req_mode <= 3'd5;
        err_c    = req_vld && (!legal || (uses_ptr && !sel_ok) ||
                               (mode == AM_DISP && req_sel == PSEL_P0));
        do_wb    = req_vld && !err_c && ((mode == AM_PREDEC) || (mode == AM_POSTINC));
        ea_m     = err_c ? '0 : ea_c;

        st_d = '0;
        if (req_vld) begin
            st_d.vld    = 1'b1;
            st_d.ea     = ea_m;
            st_d.region = region_c;
            st_d.bit_ok = bit_ok_c;
            st_d.err    = err_c;
            st_d.wb     = do_wb;
            st_d.wb_sel = do_wb ? req_sel : 2'd0;
            st_d.wb_val = do_wb ? wb_c : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld    = st_q.vld;
    assign out_ea     = st_q.ea;
    assign out_region = st_q.region;
    assign out_bit_ok = st_q.bit_ok;
    assign out_err    = st_q.err;
    assign wb_vld     = st_q.wb;
    assign wb_sel     = st_q.wb_sel;
    assign wb_lo      = st_q.wb_val[HALF-1:0];
    assign wb_hi      = st_q.wb_val[ADDR_W-1:HALF];
endmodule

// File: rtl/agu_chk.sv
module agu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_vld,
    input logic [2:0]  req_mode,
    input logic        out_vld,
    input logic [15:0] out_ea,
    input logic [1:0]  out_region,
    input logic        out_bit_ok,
    input logic        out_err,
    input logic        wb_vld,
    input logic [7:0]  wb_lo,
    input logic [7:0]  wb_hi
);
    logic seen;
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    p_vld_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (out_vld == $past(req_vld)));

    p_wb_within_vld_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_vld |-> out_vld);

    p_err_no_wb_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> !wb_vld);

    p_predec_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && wb_vld && $past(req_mode) == 3'd3) |-> ({wb_hi, wb_lo} == out_ea));

    p_postinc_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && wb_vld && $past(req_mode) == 3'd4) |-> ({wb_hi, wb_lo} == out_ea + 16'd1));

    p_bit_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_bit_ok |-> (out_ea >= 16'd32 && out_ea < 16'd64));

    p_out_of_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_ea >= 16'd1120) |-> (out_region == 2'd3));

    p_gpr_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_ea < 16'd32) |-> (out_region == 2'd0));
endmodule

bind data_agu agu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_mode(req_mode),
    .out_vld(out_vld), .out_ea(out_ea), .out_region(out_region),
    .out_bit_ok(out_bit_ok), .out_err(out_err), .wb_vld(wb_vld),
    .wb_lo(wb_lo), .wb_hi(wb_hi)
);

// File: tb/sim_data_agu.sv
`timescale 1ns/1ps
module sim_data_agu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [2:0]  req_mode = '0;
    logic [1:0]  req_sel = '0;
    logic [15:0] req_dir = '0;
    logic [5:0]  req_disp = '0;
    logic [5:0]  req_io = '0;
    logic        gpr_we = 1'b0;
    logic [4:0]  gpr_idx = '0;
    logic [7:0]  gpr_data = '0;
    logic        out_vld, out_bit_ok, out_err, wb_vld;
    logic [15:0] out_ea;
    logic [1:0]  out_region, wb_sel;
    logic [7:0]  wb_lo, wb_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    data_agu u0 (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_mode(req_mode),
        .req_sel(req_sel), .req_dir(req_dir), .req_disp(req_disp), .req_io(req_io),
        .gpr_we(gpr_we), .gpr_idx(gpr_idx), .gpr_data(gpr_data),
        .out_vld(out_vld), .out_ea(out_ea), .out_region(out_region),
        .out_bit_ok(out_bit_ok), .out_err(out_err), .wb_vld(wb_vld),
        .wb_sel(wb_sel), .wb_lo(wb_lo), .wb_hi(wb_hi)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one clock: request and register-port write together
    task automatic step(bit rv, logic [2:0] m, logic [1:0] s, logic [15:0] d,
                        logic [5:0] ds, logic [5:0] io, bit we, logic [4:0] ix, logic [7:0] dat);
        @(negedge clk);
        req_vld = rv; req_mode = m; req_sel = s; req_dir = d; req_disp = ds; req_io = io;
        gpr_we = we; gpr_idx = ix; gpr_data = dat;
        @(posedge clk);
        #1;
        req_vld = 1'b0; gpr_we = 1'b0;
    endtask

    task automatic req(logic [2:0] m, logic [1:0] s, logic [15:0] d, logic [5:0] ds, logic [5:0] io);
        step(1'b1, m, s, d, ds, io, 1'b0, 5'd0, 8'd0);
    endtask

    task automatic wr(logic [4:0] ix, logic [7:0] dat);
        step(1'b0, 3'd0, 2'd0, 16'd0, 6'd0, 6'd0, 1'b1, ix, dat);
    endtask

    task automatic set_ptr(logic [1:0] s, logic [15:0] v);
        wr(5'd26 + {2'b0, s, 1'b0}, v[7:0]);
        wr(5'd27 + {2'b0, s, 1'b0}, v[15:8]);
    endtask

    task automatic expect_ptr(string tag, logic [1:0] s, logic [15:0] v);
        req(3'd1, s, 16'd0, 6'd0, 6'd0);
        chk(tag, out_ea, v);
    endtask

    task automatic t_reset;
        chk("R1 out_vld", out_vld, 0);
        chk("R1 out_ea", out_ea, 0);
        chk("R1 wb_vld", wb_vld, 0);
        chk("R1 region", out_region, 0);
        expect_ptr("R1 P0", 2'd0, 16'h0000);
        expect_ptr("R1 P2", 2'd2, 16'h0000);
    endtask

    task automatic t_shadow;
        set_ptr(2'd0, 16'h1234);
        req(3'd1, 2'd0, 16'd0, 6'd0, 6'd0);
        chk("R4 ind ea", out_ea, 16'h1234);
        chk("R4 ind no wb", wb_vld, 0);
        wr(5'd5, 8'hFF);
        wr(5'd25, 8'hEE);
        expect_ptr("R2 low index ignored P0", 2'd0, 16'h1234);
        expect_ptr("R2 low index ignored P1", 2'd1, 16'h0000);
        wr(5'd29, 8'hAB);
        expect_ptr("R2 hi byte P1", 2'd1, 16'hAB00);
    endtask

    task automatic t_direct;
        req(3'd0, 2'd0, 16'hFFFF, 6'd0, 6'd0);
        chk("R3 ea ffff", out_ea, 16'hFFFF);
        chk("R3 no wb", wb_vld, 0);
        chk("R9 ffff region", out_region, 3);
        req(3'd0, 2'd0, 16'd1119, 6'd0, 6'd0);
        chk("R9 1119 region", out_region, 2);
        req(3'd0, 2'd0, 16'd1120, 6'd0, 6'd0);
        chk("R9 1120 region", out_region, 3);
        req(3'd0, 2'd0, 16'd31, 6'd0, 6'd0);
        chk("R9 31 region", out_region, 0);
        req(3'd0, 2'd0, 16'd32, 6'd0, 6'd0);
        chk("R9 32 region", out_region, 1);
        req(3'd0, 2'd0, 16'd95, 6'd0, 6'd0);
        chk("R9 95 region", out_region, 1);
        req(3'd0, 2'd0, 16'd96, 6'd0, 6'd0);
        chk("R9 96 region", out_region, 2);
        chk("R3 ea 96", out_ea, 16'd96);
    endtask

    task automatic t_disp;
        set_ptr(2'd1, 16'h0100);
        req(3'd2, 2'd1, 16'd0, 6'd63, 6'd0);
        chk("R5 P1+63", out_ea, 16'h013F);
        chk("R5 no wb", wb_vld, 0);
        set_ptr(2'd2, 16'hFFF0);
        req(3'd2, 2'd2, 16'd0, 6'h20, 6'd0);
        chk("R5 wrap", out_ea, 16'h0010);
        req(3'd2, 2'd0, 16'd0, 6'd5, 6'd0);
        chk("R5 P0 err", out_err, 1);
        chk("R5 P0 no wb", wb_vld, 0);
    endtask

    task automatic t_predec;
        set_ptr(2'd2, 16'h0061);
        req(3'd3, 2'd2, 16'd0, 6'd0, 6'd0);
        chk("R6 ea", out_ea, 16'h0060);
        chk("R6 wb_vld", wb_vld, 1);
        chk("R10 wb_sel", wb_sel, 2);
        chk("R10 wb_lo", wb_lo, 8'h60);
        chk("R10 wb_hi", wb_hi, 8'h00);
        expect_ptr("R6 stored", 2'd2, 16'h0060);
        set_ptr(2'd0, 16'h0000);
        req(3'd3, 2'd0, 16'd0, 6'd0, 6'd0);
        chk("R6 wrap ea", out_ea, 16'hFFFF);
        chk("R6 wrap hi", wb_hi, 8'hFF);
    endtask

    task automatic t_postinc;
        set_ptr(2'd1, 16'h00FF);
        req(3'd4, 2'd1, 16'd0, 6'd0, 6'd0);
        chk("R7 ea old", out_ea, 16'h00FF);
        chk("R7 wb hi", wb_hi, 8'h01);
        chk("R7 wb lo", wb_lo, 8'h00);
        expect_ptr("R7 stored", 2'd1, 16'h0100);
        set_ptr(2'd2, 16'hFFFF);
        req(3'd4, 2'd2, 16'd0, 6'd0, 6'd0);
        chk("R7 wrap wb", {wb_hi, wb_lo}, 16'h0000);
    endtask

    task automatic t_io;
        req(3'd5, 2'd0, 16'd0, 6'd0, 6'h00);
        chk("R8 io0 ea", out_ea, 16'h0020);
        chk("R8 io0 bit", out_bit_ok, 1);
        chk("R9 io0 region", out_region, 1);
        req(3'd5, 2'd0, 16'd0, 6'd0, 6'h1F);
        chk("R8 io1f bit", out_bit_ok, 1);
        req(3'd5, 2'd0, 16'd0, 6'd0, 6'h20);
        chk("R8 io20 ea", out_ea, 16'h0040);
        chk("R8 io20 bit", out_bit_ok, 0);
        req(3'd5, 2'd0, 16'd0, 6'd0, 6'h3F);
        chk("R8 io3f ea", out_ea, 16'h005F);
    endtask

    task automatic t_latency;
        req(3'd4, 2'd0, 16'd0, 6'd0, 6'd0);
        chk("R10 vld pulse on", out_vld, 1);
        @(posedge clk); #1;
        chk("R10 vld pulse off", out_vld, 0);
        chk("R10 wb pulse off", wb_vld, 0);
    endtask

    task automatic t_collide;
        set_ptr(2'd0, 16'h0200);
        step(1'b1, 3'd3, 2'd0, 16'd0, 6'd0, 6'd0, 1'b1, 5'd26, 8'hAA);
        expect_ptr("R11 wb wins", 2'd0, 16'h01FF);
        set_ptr(2'd1, 16'h0300);
        step(1'b1, 3'd4, 2'd0, 16'd0, 6'd0, 6'd0, 1'b1, 5'd28, 8'h55);
        expect_ptr("R11 other pair P0", 2'd0, 16'h0200);
        expect_ptr("R11 other pair P1", 2'd1, 16'h0355);
    endtask

    task automatic t_illegal;
        req(3'd6, 2'd1, 16'h0400, 6'd0, 6'd0);
        chk("R12 mode6 err", out_err, 1);
        chk("R12 mode6 ea", out_ea, 0);
        req(3'd4, 2'd3, 16'd0, 6'd0, 6'd0);
        chk("R12 sel3 err", out_err, 1);
        chk("R12 sel3 no wb", wb_vld, 0);
        chk("R12 sel3 region", out_region, 0);
        req(3'd0, 2'd3, 16'h0050, 6'd0, 6'd0);
        chk("R12 sel ignored direct", out_err, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset;
        t_shadow;
        t_direct;
        t_disp;
        t_predec;
        t_postinc;
        t_io;
        t_latency;
        t_collide;
        t_illegal;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule